// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the software-facing half of a master-only SPI controller. It decodes a simple 32-bit register bus and holds the configuration the serial engine needs: a control word, an enable bit, chip-select lines and an even clock divider. It also owns two FIFOs of parametric depth. A write to the transmit data port adds one entry to the transmit queue, and the serial engine drains that queue through a valid/ready stream. Received entries come in from the engine and are popped by reading the receive data port.

Interrupts depend on FIFO occupancy against two programmable thresholds. The transmit source fires when the transmit queue has drained to its threshold or below. The receive source fires when the receive queue holds more entries than its threshold. Both sources latch into a raw register. A mask gates them into a status register, a write-one-to-clear register clears them, and a single interrupt line reports any unmasked source. A threshold register keeps only the bits that address the FIFO depth, so software can find the depth by writing growing values until a readback differs.

Clearing the enable bit holds both queues empty. While the block is disabled the engine is offered no data and received entries are not accepted.

Top module: `spi_regfront`

## Requirements
- R1: After reset every register reads 0, `irq_o` and `enable_o` are 0, `tx_valid_o` is 0 and every `cs_n_o` line is 1.
- R2: The control register (0x000) reads back the full 32-bit value written to it. The divider register (0x010) keeps bits 15:1 of the written value and reads bit 0 as 0.
- R3: The TX threshold (0x014) and RX threshold (0x018) registers keep only the low log2(DEPTH) bits of a write. With DEPTH=32, a write of 31 reads back 31, a write of 32 reads back 0, and a write of 0x2A reads back 0x0A.
- R4: The chip-select register (0x00C) has one bit per select. A 1 in bit n drives `cs_n_o[n]` low from the cycle after the write.
- R5: While enabled (0x008 bit 0 = 1), each write to the data port 0x400 appends `bus_wdata_i[DW-1:0]` to the TX FIFO. `tx_data_o` presents the entries in order, a cycle with `tx_valid_o` and `tx_ready_i` both high removes one, and 0x01C reads the TX entry count.
- R6: A write to 0x400 while the TX FIFO holds DEPTH entries is dropped: the level stays at DEPTH and the head entry is unchanged.
- R7: While enabled, a cycle with `rx_valid_i` high stores `rx_data_i` in the RX FIFO. 0x020 reads the RX entry count, and each read of 0x800 returns the oldest entry and removes it.
- R8: While the enable bit is 0, both FIFOs are emptied and held empty.
- R9: Raw interrupt (0x034) bit 0 latches when enabled and the TX level is less than or equal to the TX threshold. Bit 4 latches when enabled and the RX level is greater than the RX threshold. A latched bit stays set after its condition ends.
- R10: The mask register (0x02C) keeps only bits 0 and 4. The status register (0x030) reads raw AND mask, and `irq_o` is 1 exactly when a status bit is 1.
- R11: Writing 0x038 clears each raw bit whose write-data bit is 1, and the cleared bit latches again one cycle later if its condition still holds. 0x038 reads 0.
- R12: Status register (0x024) bit 0, the busy flag, is 1 while enabled and either the TX FIFO is non-empty or `eng_busy_i` is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational during a read cycle |
| irq_o | output | 1 | Interrupt request, active high |
| cfg_ctrl_o | output | 32 | Control word for the serial engine |
| cfg_div_o | output | 16 | Clock divider for the serial engine, always even |
| enable_o | output | 1 | Controller enabled |
| cs_n_o | output | NCS | Slave selects, active low |
| eng_busy_i | input | 1 | Serial engine is shifting |
| tx_valid_o | output | 1 | TX FIFO head is available to the engine |
| tx_ready_i | input | 1 | Engine takes the TX head |
| tx_data_o | output | DW | TX FIFO head entry |
| rx_valid_i | input | 1 | Engine delivers a received entry |
| rx_data_i | input | DW | Received entry |

## Verification
A bad FIFO pointer or count shows up at the ports as soon as the next level read or head check: the wrong entry appears on `tx_data_o`, or a read of 0x800 returns the wrong value. The stimulus pushes, pops, overfills and flushes so that each of these paths is observed within a few cycles. A stuck or wrongly latched interrupt bit shows on `irq_o` and on the status register one cycle after the condition, mask or clear that should have changed it. The bench reads both registers right after each such event.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;
   localparam logic [11:0] OFS_CTRL   = 12'h000;
   localparam logic [11:0] OFS_ENA    = 12'h008;
   localparam logic [11:0] OFS_SEL    = 12'h00C;
   localparam logic [11:0] OFS_DIV    = 12'h010;
   localparam logic [11:0] OFS_TXTHR  = 12'h014;
   localparam logic [11:0] OFS_RXTHR  = 12'h018;
   localparam logic [11:0] OFS_TXLVL  = 12'h01C;
   localparam logic [11:0] OFS_RXLVL  = 12'h020;
   localparam logic [11:0] OFS_STAT   = 12'h024;
   localparam logic [11:0] OFS_IMASK  = 12'h02C;
   localparam logic [11:0] OFS_ISTAT  = 12'h030;
   localparam logic [11:0] OFS_IRAW   = 12'h034;
   localparam logic [11:0] OFS_ICLR   = 12'h038;
   localparam logic [11:0] OFS_TXPORT = 12'h400;
   localparam logic [11:0] OFS_RXPORT = 12'h800;

   localparam int IRQ_W      = 5;
   localparam int IRQ_TXLOW  = 0;
   localparam int IRQ_RXHIGH = 4;
   localparam int IRQ_NSRC   = 2;
endpackage

// File: rtl/spi_regfront_fifo.sv
module spi_regfront_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          flush_i,
   input  logic          push_i,
   input  logic [DW-1:0] data_i,
   input  logic          pop_i,
   output logic [DW-1:0] data_o,
   output logic [LW-1:0] level_o,
   output logic          full_o,
   output logic          empty_o
);
   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] wptr_q, rptr_q;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full_o  = (cnt_q == LW'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i && !full_o && !flush_i;
   assign do_pop  = pop_i && !empty_o && !flush_i;
   assign data_o  = mem_q[rptr_q];
   assign level_o = cnt_q;

   always_ff @(posedge clk_i) begin
      if (do_push) mem_q[wptr_q] <= data_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_q + PW'(1);
         if (do_pop)  rptr_q <= rptr_q + PW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + LW'(1);
            2'b01:   cnt_q <= cnt_q - LW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/spi_regfront_irq.sv
module spi_regfront_irq
   import spi_regfront_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [LW-1:0]    tx_lvl_i,
   input  logic [LW-1:0]    rx_lvl_i,
   input  logic [PW-1:0]    tx_thr_i,
   input  logic [PW-1:0]    rx_thr_i,
   input  logic             mask_we_i,
   input  logic             clr_we_i,
   input  logic [IRQ_W-1:0] wdata_i,
   output logic [IRQ_W-1:0] raw_o,
   output logic [IRQ_W-1:0] mask_o,
   output logic [IRQ_W-1:0] stat_o,
   output logic             irq_o
);
   localparam int SRC_POS [IRQ_NSRC] = '{IRQ_TXLOW, IRQ_RXHIGH};

   logic [IRQ_NSRC-1:0] src_hit;
   logic [IRQ_W-1:0]    cond_vec, impl_vec;

   assign src_hit[0] = en_i && (tx_lvl_i <= {1'b0, tx_thr_i});
   assign src_hit[1] = en_i && (rx_lvl_i >  {1'b0, rx_thr_i});

   genvar gi;
   generate
      for (gi = 0; gi < IRQ_W; gi++) begin : g_bit
         logic hit_here;
         logic impl_here;
         always_comb begin
            hit_here  = 1'b0;
            impl_here = 1'b0;
            for (int s = 0; s < IRQ_NSRC; s++) begin
               if (SRC_POS[s] == gi) begin
                  hit_here  = src_hit[s];
                  impl_here = 1'b1;
               end
            end
         end
         assign cond_vec[gi] = hit_here;
         assign impl_vec[gi] = impl_here;
      end
   endgenerate

   logic [IRQ_W-1:0] raw_q, mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q | cond_vec) & ~(clr_we_i ? wdata_i : '0);
         if (mask_we_i) mask_q <= wdata_i & impl_vec;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign stat_o = raw_q & mask_q;
   assign irq_o  = |stat_o;
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
   import spi_regfront_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 32,
   parameter int NCS   = 2,
   localparam int PW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           bus_valid_i,
   input  logic           bus_write_i,
   input  logic [11:0]    bus_addr_i,
   input  logic [31:0]    bus_wdata_i,
   output logic [31:0]    bus_rdata_o,
   output logic           irq_o,
   output logic [31:0]    cfg_ctrl_o,
   output logic [15:0]    cfg_div_o,
   output logic           enable_o,
   output logic [NCS-1:0] cs_n_o,
   input  logic           eng_busy_i,
   output logic           tx_valid_o,
   input  logic           tx_ready_i,
   output logic [DW-1:0]  tx_data_o,
   input  logic           rx_valid_i,
   input  logic [DW-1:0]  rx_data_i
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (NCS < 2 || NCS > 32) begin : g_bad_ncs
         $error("NCS must lie in 2..32");
      end
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("DW must lie in 1..32");
      end
   endgenerate

   logic wr, rd;
   assign wr = bus_valid_i && bus_write_i;
   assign rd = bus_valid_i && !bus_write_i;

   logic [31:0]    ctrl_q;
   logic [14:0]    div_q;
   logic           ena_q;
   logic [NCS-1:0] sel_q;
   logic [PW-1:0]  txthr_q, rxthr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         div_q   <= '0;
         ena_q   <= 1'b0;
         sel_q   <= '0;
         txthr_q <= '0;
         rxthr_q <= '0;
      end else if (wr) begin
         case (bus_addr_i)
            OFS_CTRL:  ctrl_q  <= bus_wdata_i;
            OFS_DIV:   div_q   <= bus_wdata_i[15:1];
            OFS_ENA:   ena_q   <= bus_wdata_i[0];
            OFS_SEL:   sel_q   <= bus_wdata_i[NCS-1:0];
            OFS_TXTHR: txthr_q <= bus_wdata_i[PW-1:0];
            OFS_RXTHR: rxthr_q <= bus_wdata_i[PW-1:0];
            default:   ;
         endcase
      end
   end

   assign cfg_ctrl_o = ctrl_q;
   assign cfg_div_o  = {div_q, 1'b0};
   assign enable_o   = ena_q;
   assign cs_n_o     = ~sel_q;

   logic [LW-1:0] tx_lvl, rx_lvl;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic [DW-1:0] rx_head;

   spi_regfront_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!ena_q),
      .push_i  (wr && bus_addr_i == OFS_TXPORT),
      .data_i  (bus_wdata_i[DW-1:0]),
      .pop_i   (tx_ready_i),
      .data_o  (tx_data_o),
      .level_o (tx_lvl),
      .full_o  (tx_full),
      .empty_o (tx_empty)
   );

   spi_regfront_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (!ena_q),
      .push_i  (rx_valid_i),
      .data_i  (rx_data_i),
      .pop_i   (rd && bus_addr_i == OFS_RXPORT),
      .data_o  (rx_head),
      .level_o (rx_lvl),
      .full_o  (rx_full),
      .empty_o (rx_empty)
   );

   assign tx_valid_o = ena_q && !tx_empty;

   logic [IRQ_W-1:0] irq_raw, irq_mask, irq_stat;

   spi_regfront_irq #(.DEPTH(DEPTH)) u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (ena_q),
      .tx_lvl_i  (tx_lvl),
      .rx_lvl_i  (rx_lvl),
      .tx_thr_i  (txthr_q),
      .rx_thr_i  (rxthr_q),
      .mask_we_i (wr && bus_addr_i == OFS_IMASK),
      .clr_we_i  (wr && bus_addr_i == OFS_ICLR),
      .wdata_i   (bus_wdata_i[IRQ_W-1:0]),
      .raw_o     (irq_raw),
      .mask_o    (irq_mask),
      .stat_o    (irq_stat),
      .irq_o     (irq_o)
   );

   logic busy;
   assign busy = ena_q && (eng_busy_i || !tx_empty);

   always_comb begin
      bus_rdata_o = '0;
      if (rd) begin
         case (bus_addr_i)
            OFS_CTRL:   bus_rdata_o = ctrl_q;
            OFS_ENA:    bus_rdata_o = {31'b0, ena_q};
            OFS_SEL:    bus_rdata_o = 32'(sel_q);
            OFS_DIV:    bus_rdata_o = {16'b0, div_q, 1'b0};
            OFS_TXTHR:  bus_rdata_o = 32'(txthr_q);
            OFS_RXTHR:  bus_rdata_o = 32'(rxthr_q);
            OFS_TXLVL:  bus_rdata_o = 32'(tx_lvl);
            OFS_RXLVL:  bus_rdata_o = 32'(rx_lvl);
            OFS_STAT:   bus_rdata_o = {31'b0, busy};
            OFS_IMASK:  bus_rdata_o = 32'(irq_mask);
            OFS_ISTAT:  bus_rdata_o = 32'(irq_stat);
            OFS_IRAW:   bus_rdata_o = 32'(irq_raw);
            OFS_RXPORT: bus_rdata_o = rx_empty ? '0 : 32'(rx_head);
            default:    bus_rdata_o = '0;
         endcase
      end
   end

   logic unused_ok;
   assign unused_ok = rx_full ^ tx_full;
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk
   import spi_regfront_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int NCS   = 2,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             bus_valid_i,
   input logic             bus_write_i,
   input logic [11:0]      bus_addr_i,
   input logic [31:0]      bus_wdata_i,
   input logic             enable_o,
   input logic             tx_ready_i,
   input logic [NCS-1:0]   cs_n_o,
   input logic [LW-1:0]    tx_lvl,
   input logic [LW-1:0]    rx_lvl,
   input logic [IRQ_W-1:0] irq_raw
);
   logic wr;
   assign wr = bus_valid_i && bus_write_i;

   assert_level_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

   assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && bus_addr_i == OFS_TXPORT && enable_o && tx_lvl == LW'(DEPTH) && !tx_ready_i)
      |=> tx_lvl == LW'(DEPTH));

   assert_select_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && bus_addr_i == OFS_SEL) |=> cs_n_o == ~$past(bus_wdata_i[NCS-1:0]));

   assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_o |=> (tx_lvl == '0) && (rx_lvl == '0));

   assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && bus_addr_i == OFS_ICLR && bus_wdata_i[IRQ_TXLOW] && !enable_o)
      |=> !irq_raw[IRQ_TXLOW]);
endmodule

bind spi_regfront spi_regfront_chk #(.DEPTH(DEPTH), .NCS(NCS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .enable_o    (enable_o),
   .tx_ready_i  (tx_ready_i),
   .cs_n_o      (cs_n_o),
   .tx_lvl      (tx_lvl),
   .rx_lvl      (rx_lvl),
   .irq_raw     (irq_raw)
);

// File: tb/spi_regfront_test.sv
module spi_regfront_test;
   localparam int DW = 8, DEPTH = 32, NCS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bv = 0, bw = 0;
   logic [11:0] ba = '0;
   logic [31:0] bd = '0, rdata;
   logic irq, ena;
   logic [31:0] ctrl;
   logic [15:0] div;
   logic [NCS-1:0] csn;
   logic busy_in = 0, txv, txr = 0, rxv = 0;
   logic [DW-1:0] txd, rxd = '0;

   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   spi_regfront #(.DW(DW), .DEPTH(DEPTH), .NCS(NCS)) uut (
      .clk_i(clk), .rst_ni(rst_n),
      .bus_valid_i(bv), .bus_write_i(bw), .bus_addr_i(ba), .bus_wdata_i(bd),
      .bus_rdata_o(rdata), .irq_o(irq), .cfg_ctrl_o(ctrl), .cfg_div_o(div),
      .enable_o(ena), .cs_n_o(csn), .eng_busy_i(busy_in),
      .tx_valid_o(txv), .tx_ready_i(txr), .tx_data_o(txd),
      .rx_valid_i(rxv), .rx_data_i(rxd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk); bv = 1; bw = 1; ba = a; bd = d;
      @(negedge clk); bv = 0; bw = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk); bv = 1; bw = 0; ba = a;
      #1 d = rdata;
      @(negedge clk); bv = 0;
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   // address, write data, expected readback
   localparam int NV = 9;
   localparam logic [75:0] VEC [NV] = '{
      {12'h000, 32'hDEADBEEF, 32'hDEADBEEF},
      {12'h000, 32'h00001234, 32'h00001234},
      {12'h010, 32'h00000013, 32'h00000012},
      {12'h010, 32'h0001FFFF, 32'h0000FFFE},
      {12'h014, 32'h00000005, 32'h00000005},
      {12'h014, 32'h0000001F, 32'h0000001F},
      {12'h014, 32'h00000020, 32'h00000000},
      {12'h018, 32'h0000002A, 32'h0000000A},
      {12'h00C, 32'h00000003, 32'h00000003}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 enable", 32'(ena), 0);
      chk("R1 txvalid", 32'(txv), 0);
      chk("R1 cs_n", 32'(csn), 32'h3);
      rdchk("R1 ctrl", 12'h000, 0);
      rdchk("R1 div", 12'h010, 0);
      rdchk("R1 raw", 12'h034, 0);

      // R2 / R3 / R4 register vectors
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rdchk((VEC[i][75:64] == 12'h014 || VEC[i][75:64] == 12'h018) ? "R3 thr" :
               (VEC[i][75:64] == 12'h00C) ? "R4 sel" : "R2 reg",
               VEC[i][75:64], VEC[i][31:0]);
      end
      chk("R4 cs_n both", 32'(csn), 0);
      wr(12'h00C, 32'h2);
      chk("R4 cs_n one", 32'(csn), 32'h1);
      chk("R2 div port", 32'(div), 32'hFFFE);
      chk("R2 ctrl port", ctrl, 32'h1234);

      // R5 push while enabled
      wr(12'h014, 0);
      wr(12'h018, 1);
      wr(12'h008, 1);
      wr(12'h400, 32'hA1); wr(12'h400, 32'hA2); wr(12'h400, 32'hA3);
      rdchk("R5 txlvl", 12'h01C, 3);
      chk("R5 head", 32'(txd), 32'hA1);
      chk("R5 valid", 32'(txv), 1);
      rdchk("R12 busy fifo", 12'h024, 1);
      @(negedge clk); txr = 1;
      @(negedge clk); txr = 0;
      chk("R5 head after pop", 32'(txd), 32'hA2);
      rdchk("R5 txlvl after pop", 12'h01C, 2);
      @(negedge clk); txr = 1;
      @(negedge clk); @(negedge clk); txr = 0;
      rdchk("R5 txlvl drained", 12'h01C, 0);
      rdchk("R12 idle", 12'h024, 0);
      busy_in = 1;
      rdchk("R12 engine busy", 12'h024, 1);
      busy_in = 0;

      // R7 receive path
      @(negedge clk); rxv = 1; rxd = 8'h5C;
      @(negedge clk); rxd = 8'h6D;
      @(negedge clk); rxv = 0;
      rdchk("R7 rxlvl", 12'h020, 2);
      // R9 rx level 2 > threshold 1
      rdchk("R9 raw both", 12'h034, 32'h11);
      rdchk("R7 pop first", 12'h800, 32'h5C);
      rdchk("R7 pop second", 12'h800, 32'h6D);
      rdchk("R7 rxlvl empty", 12'h020, 0);
      rdchk("R9 raw sticky", 12'h034, 32'h11);

      // R10 mask and status
      chk("R10 irq unmasked", 32'(irq), 0);
      wr(12'h02C, 32'h1F);
      rdchk("R10 mask bits", 12'h02C, 32'h11);
      wr(12'h02C, 32'h01);
      rdchk("R10 status", 12'h030, 32'h01);
      chk("R10 irq", 32'(irq), 1);

      // R11 clear
      wr(12'h400, 32'hB0);
      wr(12'h038, 32'h11);
      rdchk("R11 raw cleared", 12'h034, 0);
      chk("R11 irq low", 32'(irq), 0);
      rdchk("R11 clr reads 0", 12'h038, 0);
      @(negedge clk); txr = 1;
      @(negedge clk); txr = 0;
      rdchk("R11 relatch", 12'h034, 32'h01);
      chk("R10 irq again", 32'(irq), 1);

      // R6 overflow
      for (int k = 0; k < DEPTH + 2; k++) wr(12'h400, 32'(k + 8'h40));
      rdchk("R6 full level", 12'h01C, DEPTH);
      chk("R6 head kept", 32'(txd), 32'h40);

      // R8 disable flushes
      @(negedge clk); rxv = 1; rxd = 8'h77;
      @(negedge clk); rxv = 0;
      wr(12'h008, 0);
      rdchk("R8 tx flushed", 12'h01C, 0);
      rdchk("R8 rx flushed", 12'h020, 0);
      chk("R8 no valid", 32'(txv), 0);
      wr(12'h400, 32'h99);
      rdchk("R8 held empty", 12'h01C, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule